// File: doc/BRIEF.md
# Fault Trigger Status Register

This block holds the status of eight comparator trigger inputs that feed the fault path of a motor-control PWM. A mode input selects one of two views. In live view, a read returns the present level of each trigger, and writes do nothing. In sticky view, each bit records that its trigger has been high at some point. The bit keeps that record until software writes a 1 to that bit position. Writing 0 to a bit leaves it alone.

The register sits behind an external address decoder. It sees only a write strobe, a 32-bit write data word and a 32-bit read data word. Writes reach the sticky bits only while a separate extension-enable input is high. Each bit reports its own trigger, whether or not that trigger is enabled for fault action anywhere else. The triggers are synchronous to the register clock and act on level.

Top module: `trig_status_reg`

## Requirements
- R1: Read data bits 31:8 are always 0. Bit i of read data (i = 0..7) belongs to trigger input bit i.
- R2: With `latch_mode_i` = 0 (live view), read data bits 7:0 equal `trig_i` in the same cycle, with no register delay.
- R3: With `latch_mode_i` = 1 (sticky view), a bit becomes 1 on the clock edge after its trigger is sampled high. It then stays 1 after the trigger drops, until it is cleared.
- R4: In sticky view, with `ext_en_i` = 1, a write with a 1 at bit i clears bit i on the next edge. A write with a 0 at bit i leaves bit i unchanged.
- R5: While `ext_en_i` = 0, writes have no effect on any bit, even in sticky view.
- R6: In live view, writes have no effect on read data.
- R7: Synchronous active-high `rst` clears every sticky bit to 0.
- R8: If a trigger is high in the same cycle as a write-1 clear of its bit, the bit stays 1.
- R9: The sticky bits follow the trigger levels on every edge in live view. On entry to sticky view, read data therefore shows the trigger levels sampled on the last live-view edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| latch_mode_i | input | 1 | 0 = live view, 1 = sticky view |
| ext_en_i | input | 1 | Extension enable; writes act only when 1 |
| trig_i | input | 8 | Comparator trigger levels, active high |
| wr_en_i | input | 1 | Write strobe for this register |
| wr_data_i | input | 32 | Write data; a 1 requests a clear |
| rd_data_o | output | 32 | Read data |

## Verification
The only internal state is the eight sticky flops. Any corruption of them appears at `rd_data_o` as soon as sticky view is selected, in the same cycle, because read data is combinational. In live view a stale or wrong flop stays hidden. It becomes visible on the first sticky-view read, which is why the mode-entry case (R9) is checked directly. A clear gated wrongly, or a set that loses to a clear, shows up one edge after the write.

// File: rtl/trig_stat_pkg.sv
package trig_stat_pkg;
    localparam int NUM_TRIG = 8;
    localparam int REG_W    = 32;

    typedef enum logic {
        VIEW_LIVE   = 1'b0,
        VIEW_STICKY = 1'b1
    } view_t;

    typedef struct packed {
        view_t view;
        logic  clr_ok;
    } ctrl_t;

    function automatic logic sticky_next(input view_t v, input logic trig,
                                         input logic cur, input logic clr);
        if (v == VIEW_LIVE) return trig;
        return trig | (cur & ~clr);
    endfunction
endpackage

// File: rtl/trig_sticky_bank.sv
module trig_sticky_bank
    import trig_stat_pkg::*;
#(
    parameter int N = NUM_TRIG
) (
    input  logic         clk,
    input  logic         rst,
    input  ctrl_t        ctrl,
    input  logic [N-1:0] trig,
    input  logic [N-1:0] clr_req,
    output logic [N-1:0] sticky_q
);
    logic [N-1:0] clr_eff;
    assign clr_eff = clr_ctrl(ctrl, clr_req);

    function automatic logic [N-1:0] clr_ctrl(input ctrl_t c, input logic [N-1:0] r);
        return (c.clr_ok && c.view == VIEW_STICKY) ? r : '0;
    endfunction

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) sticky_q[i] <= 1'b0;
            else     sticky_q[i] <= sticky_next(ctrl.view, trig[i], sticky_q[i], clr_eff[i]);
        end

        assert_set_R3: assert property (@(posedge clk) disable iff (rst)
            (ctrl.view == VIEW_STICKY && trig[i]) |=> sticky_q[i]);
        assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
            (ctrl.view == VIEW_STICKY && sticky_q[i] && !clr_req[i]) |=> sticky_q[i]);
        assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
            (ctrl.view == VIEW_STICKY && ctrl.clr_ok && clr_req[i] && !trig[i]) |=> !sticky_q[i]);
        assert_gate_R5: assert property (@(posedge clk) disable iff (rst)
            (ctrl.view == VIEW_STICKY && !ctrl.clr_ok && sticky_q[i]) |=> sticky_q[i]);
        assert_follow_R9: assert property (@(posedge clk) disable iff (rst)
            (ctrl.view == VIEW_LIVE) |=> (sticky_q[i] == $past(trig[i])));
    end

    assert_reset_R7: assert property (@(posedge clk) rst |=> (sticky_q == '0));
endmodule

// File: rtl/trig_read_sel.sv
module trig_read_sel
    import trig_stat_pkg::*;
#(
    parameter int N = NUM_TRIG,
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  view_t        view,
    input  logic [N-1:0] live,
    input  logic [N-1:0] sticky,
    output logic [W-1:0] rd_data
);
    localparam int PAD = W - N;

    logic [N-1:0] sel;
    always_comb begin
        unique case (view)
            VIEW_LIVE:   sel = live;
            VIEW_STICKY: sel = sticky;
            default:     sel = live;
        endcase
    end
    assign rd_data = {{PAD{1'b0}}, sel};

    assert_upper_zero_R1: assert property (@(posedge clk) disable iff (rst)
        rd_data[W-1:N] == '0);
    assert_live_R2: assert property (@(posedge clk) disable iff (rst)
        (view == VIEW_LIVE) |-> (rd_data[N-1:0] == live));
endmodule

// File: rtl/trig_status_reg.sv
module trig_status_reg
    import trig_stat_pkg::*;
#(
    parameter int N = NUM_TRIG,
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         latch_mode_i,
    input  logic         ext_en_i,
    input  logic [N-1:0] trig_i,
    input  logic         wr_en_i,
    input  logic [W-1:0] wr_data_i,
    output logic [W-1:0] rd_data_o
);
    ctrl_t        ctrl;
    logic [N-1:0] clr_req;
    logic [N-1:0] sticky_q;

    assign ctrl.view   = latch_mode_i ? VIEW_STICKY : VIEW_LIVE;
    assign ctrl.clr_ok = ext_en_i;
    assign clr_req     = wr_en_i ? wr_data_i[N-1:0] : '0;

    trig_sticky_bank #(.N(N)) u_bank (
        .clk(clk), .rst(rst), .ctrl(ctrl), .trig(trig_i),
        .clr_req(clr_req), .sticky_q(sticky_q)
    );

    trig_read_sel #(.N(N), .W(W)) u_rd (
        .clk(clk), .rst(rst), .view(ctrl.view), .live(trig_i),
        .sticky(sticky_q), .rd_data(rd_data_o)
    );

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (latch_mode_i && wr_en_i && ext_en_i && (trig_i & wr_data_i[N-1:0]) != '0)
        |=> latch_mode_i |-> ((rd_data_o[N-1:0] & $past(trig_i & wr_data_i[N-1:0]))
                              == $past(trig_i & wr_data_i[N-1:0])));
    assert_live_write_R6: assert property (@(posedge clk) disable iff (rst)
        (!latch_mode_i && wr_en_i) |-> (rd_data_o[N-1:0] == trig_i));
endmodule

// File: tb/test_trig_status_reg.sv
module test_trig_status_reg;
    logic        clk = 1'b0;
    logic        rst;
    logic        latch_mode_i, ext_en_i, wr_en_i;
    logic [7:0]  trig_i;
    logic [31:0] wr_data_i, rd_data_o;
    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    trig_status_reg i_trig_status_reg (
        .clk(clk), .rst(rst), .latch_mode_i(latch_mode_i), .ext_en_i(ext_en_i),
        .trig_i(trig_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o)
    );

    task automatic check(input string tag, input logic [31:0] exp);
        #1;
        checks++;
        if (rd_data_o !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, rd_data_o, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1; latch_mode_i = 1; ext_en_i = 0; wr_en_i = 0; wr_data_i = 0; trig_i = 0;
        tick(); tick();
        rst = 0;
        check("R7 reset state", 32'h0);
    endtask

    task automatic t_live;
        latch_mode_i = 0;
        trig_i = 8'hA5; check("R2 live A5", 32'hA5);
        trig_i = 8'h5A; check("R2 live 5A", 32'h5A);
        trig_i = 8'hFF; check("R1 upper zero live FF", 32'hFF);
        tick();
        trig_i = 8'h01; check("R2 live same cycle", 32'h01);
    endtask

    task automatic t_live_write;
        latch_mode_i = 0; ext_en_i = 1; trig_i = 8'h3C;
        wr_en_i = 1; wr_data_i = 32'hFFFF_FFFF;
        check("R6 live write same cycle", 32'h3C);
        tick();
        wr_en_i = 0;
        check("R6 live write after edge", 32'h3C);
    endtask

    task automatic t_enter;
        latch_mode_i = 0; trig_i = 8'h81; tick();
        latch_mode_i = 1; trig_i = 8'h00;
        check("R9 entry shows last live", 32'h81);
    endtask

    task automatic t_sticky;
        ext_en_i = 1; wr_en_i = 1; wr_data_i = 32'hFF; tick();
        wr_en_i = 0;
        check("R4 clear all", 32'h0);
        trig_i = 8'h24; tick();
        trig_i = 8'h00;
        check("R3 set by pulse", 32'h24);
        tick(); tick(); tick();
        check("R3 held", 32'h24);
    endtask

    task automatic t_clear;
        wr_en_i = 1; wr_data_i = 32'h04; tick();
        wr_en_i = 0;
        check("R4 clear one bit", 32'h20);
        wr_en_i = 1; wr_data_i = 32'h00; tick();
        wr_en_i = 0;
        check("R4 write zero no effect", 32'h20);
    endtask

    task automatic t_gate;
        ext_en_i = 0; wr_en_i = 1; wr_data_i = 32'hFF; tick();
        wr_en_i = 0;
        check("R5 write gated off", 32'h20);
        ext_en_i = 1;
    endtask

    task automatic t_set_wins;
        trig_i = 8'h20; wr_en_i = 1; wr_data_i = 32'h20; tick();
        trig_i = 8'h00; wr_en_i = 0;
        check("R8 set wins", 32'h20);
        wr_en_i = 1; tick();
        wr_en_i = 0;
        check("R8 later clear", 32'h0);
    endtask

    task automatic t_mid_reset;
        trig_i = 8'hC3; tick();
        trig_i = 8'h00;
        check("R3 multi bit set", 32'hC3);
        rst = 1; tick();
        rst = 0;
        check("R7 reset clears", 32'h0);
    endtask

    initial begin
        fork
            begin
                t_reset(); t_live(); t_live_write(); t_enter();
                t_sticky(); t_clear(); t_gate(); t_set_wins(); t_mid_reset();
            end
            begin
                repeat (5000) @(posedge clk);
                checks++; failures++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule